// File: doc/BRIEF.md
# Microstep Indexer Translator

This block turns single step strobes into current commands for the two phases of a bipolar stepper motor. It keeps an electrical position of 32 eighth-steps per electrical cycle. Each accepted rising edge on the step input moves that position one step at the selected resolution, in the direction set by the direction input. From the position it produces, for each phase, an 8-bit magnitude code for a current-reference DAC and a polarity bit. Phase A follows the sine of the position angle and phase B follows the cosine.

Both phases read one shared quarter-wave table of nine entries. The cosine phase uses the sine lookup with the position shifted by a quarter cycle. Full-step motion always lands on a point where both phases carry the 45° level. A home flag marks the reset position. The step input is taken as synchronous to the clock. Edges are found by comparing the input with its value one cycle earlier. A step that is high for one cycle and low for one cycle is enough, so steps can arrive every other clock.

Top module: `mstep_indexer`

## Requirements
- R1: While the synchronous reset is high, the position is set to 4 (45°). One cycle after reset, mag_a = mag_b = 180, pol_a = pol_b = 1 and home = 1. A step input that is already high when reset is released is not counted as an edge.
- R2: A rising edge on step_in (low at one clock, high at the next) moves the position at that same clock edge, and the outputs show the new position right after it. A step input held high moves the position only once.
- R3: res_sel selects the stride of one step. 2'b00 is full step (8), 2'b10 is half step (4), 2'b01 is quarter step (2) and 2'b11 is eighth step (1).
- R4: With dir_fwd = 1 a step adds the stride to the position, and with dir_fwd = 0 it subtracts it. The position wraps modulo 32 both ways.
- R5: With angle = position × 11.25°, mag_a = round(255·|sin(angle)|) and mag_b = round(255·|cos(angle)|). The only codes are 0, 50, 98, 142, 180, 212, 236, 250 and 255. pol_a = 1 for positions 0 to 15 and 0 otherwise. pol_b = 1 for positions 0 to 7 and 24 to 31 and 0 otherwise.
- R6: A full step moves to the next position, in the chosen direction, that equals 4 modulo 8. From any position it therefore lands on an odd multiple of 45°, where mag_a = mag_b = 180.
- R7: While enable = 0, step edges are ignored and the outputs hold. Edge tracking goes on, so raising enable while step_in is high does not make a step.
- R8: home = 1 exactly while the position is 4.
- R9: Step strobes that alternate one cycle high and one cycle low are all counted, with no step lost.
- R10: A change of res_sel alone leaves the outputs unchanged. The new stride applies from the next step edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_in | input | 1 | Step strobe, rising edge moves one step |
| dir_fwd | input | 1 | 1 = increase position, 0 = decrease |
| res_sel | input | 2 | Step resolution code |
| enable | input | 1 | 1 = accept step edges |
| mag_a | output | 8 | Phase A magnitude code (sine) |
| pol_a | output | 1 | Phase A polarity, 1 = positive |
| mag_b | output | 8 | Phase B magnitude code (cosine) |
| pol_b | output | 1 | Phase B polarity, 1 = positive |
| home | output | 1 | High while at the home position |

## Verification
A step edge can fall in the same cycle as a change of resolution or direction, or as enable being raised while step_in is already high. The bench changes res_sel between steps and checks that the outputs do not move until the next edge. It raises enable under a held-high strobe and expects no motion. It also releases reset with step_in high and expects the home position to hold. A step on a position that is not a 45° point, with full step selected, tests the stride and the snap together, and the result is judged against a landing point the bench computes.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

    localparam int POS_W   = 5;
    localparam int MAG_W   = 8;
    localparam int OFF_W   = POS_W - 2;
    localparam int IDX_W   = OFF_W + 1;
    localparam int QSTEPS  = 1 << OFF_W;
    localparam int NPHASE  = 2;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [MAG_W-1:0] mag_t;

    localparam pos_t HOME_POS = pos_t'(QSTEPS / 2);
    localparam pos_t QUARTER  = pos_t'(QSTEPS);

    typedef enum logic [1:0] {
        RES_FULL    = 2'b00,
        RES_QUARTER = 2'b01,
        RES_HALF    = 2'b10,
        RES_EIGHTH  = 2'b11
    } res_t;

    typedef struct packed {
        mag_t mag;
        logic pol;
    } phase_t;

    function automatic mag_t quarter_wave(logic [IDX_W-1:0] k);
        case (k)
            4'd0:    return 8'd0;
            4'd1:    return 8'd50;
            4'd2:    return 8'd98;
            4'd3:    return 8'd142;
            4'd4:    return 8'd180;
            4'd5:    return 8'd212;
            4'd6:    return 8'd236;
            4'd7:    return 8'd250;
            default: return 8'd255;
        endcase
    endfunction

    function automatic phase_t sine_of(pos_t p);
        phase_t r;
        logic [IDX_W-1:0] off;
        off = {1'b0, p[OFF_W-1:0]};
        if (p[OFF_W])
            off = IDX_W'(QSTEPS) - off;
        r.mag = quarter_wave(off);
        r.pol = ~p[POS_W-1];
        return r;
    endfunction

    function automatic pos_t stride_of(res_t r);
        case (r)
            RES_FULL:    return pos_t'(QSTEPS);
            RES_HALF:    return pos_t'(QSTEPS / 2);
            RES_QUARTER: return pos_t'(QSTEPS / 4);
            default:     return pos_t'(1);
        endcase
    endfunction

    function automatic pos_t snap_full(pos_t p, logic fwd);
        pos_t t;
        if (fwd)
            t = p + HOME_POS;
        else
            t = p - HOME_POS - pos_t'(1);
        t = t & ~pos_t'(QSTEPS - 1);
        return t + HOME_POS;
    endfunction

endpackage

// File: rtl/mstep_edge.sv
module mstep_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst)
            sig_q <= 1'b1;
        else
            sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/mstep_position.sv
module mstep_position
    import mstep_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  logic fwd,
    input  res_t res,
    output pos_t pos
);
    pos_t pos_q;
    pos_t pos_next;

    always_comb begin
        pos_next = pos_q;
        if (advance) begin
            if (res == RES_FULL)
                pos_next = snap_full(pos_q, fwd);
            else if (fwd)
                pos_next = pos_q + stride_of(res);
            else
                pos_next = pos_q - stride_of(res);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= HOME_POS;
        else
            pos_q <= pos_next;
    end

    assign pos = pos_q;
endmodule

// File: rtl/mstep_phase.sv
module mstep_phase
    import mstep_pkg::*;
#(
    parameter pos_t OFFSET = '0
) (
    input  pos_t   pos,
    output phase_t phase
);
    pos_t shifted;

    assign shifted = pos + OFFSET;
    assign phase   = sine_of(shifted);
endmodule

// File: rtl/mstep_indexer.sv
module mstep_indexer
    import mstep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_in,
    input  logic             dir_fwd,
    input  logic [1:0]       res_sel,
    input  logic             enable,
    output logic [MAG_W-1:0] mag_a,
    output logic             pol_a,
    output logic [MAG_W-1:0] mag_b,
    output logic             pol_b,
    output logic             home
);
    logic   step_rise;
    pos_t   pos;
    phase_t phases [NPHASE];

    mstep_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (step_in),
        .rise   (step_rise)
    );

    mstep_position u_pos (
        .clk     (clk),
        .rst     (rst),
        .advance (step_rise & enable),
        .fwd     (dir_fwd),
        .res     (res_t'(res_sel)),
        .pos     (pos)
    );

    for (genvar g = 0; g < NPHASE; g++) begin : g_phase
        mstep_phase #(.OFFSET(pos_t'(g * QSTEPS))) u_phase (
            .pos   (pos),
            .phase (phases[g])
        );
    end

    assign mag_a = phases[0].mag;
    assign pol_a = phases[0].pol;
    assign mag_b = phases[1].mag;
    assign pol_b = phases[1].pol;
    assign home  = (pos == HOME_POS);
endmodule

// File: rtl/mstep_indexer_chk.sv
module mstep_indexer_chk (
    input logic       clk,
    input logic       rst,
    input logic       step_in,
    input logic       enable,
    input logic [1:0] res_sel,
    input logic [7:0] mag_a,
    input logic       pol_a,
    input logic [7:0] mag_b,
    input logic       pol_b,
    input logic       home
);
    // R1: first cycle after reset shows the home point
    assert_reset_home_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> home && mag_a == 8'd180 && mag_b == 8'd180);

    // R2: without a new rising edge the outputs do not move
    assert_no_edge_R2: assert property (@(posedge clk) disable iff (rst)
        !step_in |=> $stable({mag_a, pol_a, mag_b, pol_b}));

    assert_held_high_R2: assert property (@(posedge clk) disable iff (rst)
        step_in && $past(step_in) |=> $stable({mag_a, pol_a, mag_b, pol_b}));

    // R6: a full step lands on both phases at the 45 degree level
    assert_full_snap_R6: assert property (@(posedge clk) disable iff (rst)
        step_in && !$past(step_in) && enable && res_sel == 2'b00
        |=> mag_a == 8'd180 && mag_b == 8'd180);

    // R7: disabled steps leave the outputs held
    assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable({mag_a, pol_a, mag_b, pol_b}));

    // R8: home implies the 45 degree point on both phases
    assert_home_levels_R8: assert property (@(posedge clk) disable iff (rst)
        home |-> mag_a == 8'd180 && mag_b == 8'd180 && pol_a && pol_b);
endmodule

bind mstep_indexer mstep_indexer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .step_in (step_in),
    .enable  (enable),
    .res_sel (res_sel),
    .mag_a   (mag_a),
    .pol_a   (pol_a),
    .mag_b   (mag_b),
    .pol_b   (pol_b),
    .home    (home)
);

// File: tb/mstep_indexer_tb.sv
module mstep_indexer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_in = 1'b0;
    logic       dir_fwd = 1'b1;
    logic [1:0] res_sel = 2'b11;
    logic       enable = 1'b1;
    logic [7:0] mag_a, mag_b;
    logic       pol_a, pol_b, home;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int model_pos = 4;

    // {enable, dir_fwd, res_sel, expected position}
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 2'b11, 5'd5},
        {1'b1, 1'b1, 2'b11, 5'd6},
        {1'b1, 1'b1, 2'b01, 5'd8},
        {1'b1, 1'b1, 2'b10, 5'd12},
        {1'b1, 1'b1, 2'b00, 5'd20},
        {1'b1, 1'b0, 2'b00, 5'd12},
        {1'b1, 1'b0, 2'b11, 5'd11},
        {1'b1, 1'b1, 2'b00, 5'd12},
        {1'b1, 1'b0, 2'b11, 5'd11},
        {1'b1, 1'b0, 2'b00, 5'd4},
        {1'b1, 1'b0, 2'b00, 5'd28},
        {1'b1, 1'b1, 2'b10, 5'd0},
        {1'b1, 1'b0, 2'b11, 5'd31},
        {1'b1, 1'b1, 2'b01, 5'd1},
        {1'b0, 1'b1, 2'b11, 5'd1},
        {1'b1, 1'b1, 2'b00, 5'd4}
    };

    mstep_indexer u_dut (
        .clk     (clk),
        .rst     (rst),
        .step_in (step_in),
        .dir_fwd (dir_fwd),
        .res_sel (res_sel),
        .enable  (enable),
        .mag_a   (mag_a),
        .pol_a   (pol_a),
        .mag_b   (mag_b),
        .pol_b   (pol_b),
        .home    (home)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int mag_exp(int p, bit use_cos);
        real ang, v;
        ang = real'(p) * 3.14159265358979 / 16.0;
        v = use_cos ? $cos(ang) : $sin(ang);
        if (v < 0.0) v = -v;
        return int'(255.0 * v);
    endfunction

    function automatic int next_pos(int p, bit fwd, logic [1:0] res);
        int q;
        int s;
        q = p;
        if (res == 2'b00) begin
            for (int k = 0; k < 8; k++) begin
                q = fwd ? (q + 1) % 32 : (q + 31) % 32;
                if (q % 8 == 4) break;
            end
        end else begin
            s = (res == 2'b10) ? 4 : (res == 2'b01) ? 2 : 1;
            q = fwd ? (p + s) % 32 : (p + 32 - s) % 32;
        end
        return q;
    endfunction

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic check_pos(string tag, int p);
        check({tag, " mag_a"}, int'(mag_a), mag_exp(p, 1'b0));
        check({tag, " mag_b"}, int'(mag_b), mag_exp(p, 1'b1));
        check({tag, " pol_a"}, int'(pol_a), (p < 16) ? 1 : 0);
        check({tag, " pol_b"}, int'(pol_b), (p < 8 || p >= 24) ? 1 : 0);
        check({tag, " home R8"}, int'(home), (p == 4) ? 1 : 0);
    endtask

    task automatic pulse();
        @(negedge clk) step_in = 1'b1;
        @(negedge clk) step_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_pos("R1 reset", 4);

        // R3 R4 R5 R6 R7: vector walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            enable  = VEC[i][8];
            dir_fwd = VEC[i][7];
            res_sel = VEC[i][6:5];
            pulse();
            check_pos($sformatf("R3 R4 R5 R6 R7 vec%0d", i), int'(VEC[i][4:0]));
        end
        model_pos = 4;

        // R2: held-high strobe counts once; output changes right after the edge
        @(negedge clk);
        res_sel = 2'b11; dir_fwd = 1'b1; enable = 1'b1;
        @(negedge clk) step_in = 1'b1;
        @(negedge clk);
        model_pos = next_pos(model_pos, 1'b1, 2'b11);
        check_pos("R2 edge latency", model_pos);
        repeat (5) @(negedge clk);
        check_pos("R2 held high", model_pos);
        step_in = 1'b0;
        @(negedge clk);

        // R9: strobes every other cycle
        for (int k = 0; k < 8; k++) begin
            @(negedge clk) step_in = 1'b1;
            @(negedge clk) step_in = 1'b0;
            model_pos = next_pos(model_pos, 1'b1, 2'b11);
        end
        @(negedge clk);
        check_pos("R9 back to back", model_pos);

        // R10: resolution change alone does nothing; next edge uses it
        res_sel = 2'b10;
        repeat (3) @(negedge clk);
        check_pos("R10 res change hold", model_pos);
        dir_fwd = 1'b0;
        pulse();
        model_pos = next_pos(model_pos, 1'b0, 2'b10);
        check_pos("R10 new stride", model_pos);

        // R6: full step from an off-grid position, both ways
        res_sel = 2'b11; dir_fwd = 1'b1;
        pulse();
        model_pos = next_pos(model_pos, 1'b1, 2'b11);
        res_sel = 2'b00; dir_fwd = 1'b0;
        pulse();
        model_pos = next_pos(model_pos, 1'b0, 2'b00);
        check_pos("R6 snap reverse", model_pos);

        // R7: raising enable under a held-high strobe does not step
        enable = 1'b0;
        @(negedge clk) step_in = 1'b1;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        check_pos("R7 enable under high", model_pos);
        step_in = 1'b0;
        @(negedge clk);

        // R1: reset released with step high is not an edge
        res_sel = 2'b11; dir_fwd = 1'b1;
        pulse();
        step_in = 1'b1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_pos("R1 reset with step high", 4);
        step_in = 1'b0;
        @(negedge clk);

        // R4: reverse wrap through zero with quarter steps
        model_pos = 4;
        res_sel = 2'b01; dir_fwd = 1'b0;
        for (int k = 0; k < 3; k++) begin
            pulse();
            model_pos = next_pos(model_pos, 1'b0, 2'b01);
        end
        check_pos("R4 reverse wrap", model_pos);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule